// File: doc/BRIEF.md
# Ethernet destination address filter

This block decides, for each received frame, whether its 48-bit destination address should be kept or dropped. The receive path hands it the six address bytes in arrival order. A start strobe opens a new address and a byte-valid strobe qualifies each byte. While the bytes arrive, the block folds them into a running CRC-32. It also collects them into a 48-bit register.

Once the sixth byte is in, the block applies an ordered decision flow. The low bit of the first byte separates individual addresses from group addresses.

- **Individual address:** an exact match against the programmed station address wins at once. Otherwise the individual hash table decides.
- **Group address:** the fixed flow-control pause address wins when flow control is enabled. Otherwise the group hash table decides.

Each hash table has 64 bins, held as a 32-bit upper half and a 32-bit lower half. The bin is picked by the top six bits of the CRC.

The result is a one-cycle decision pulse, carrying an accept flag and a reason code. Tables, station address and the flow-control enable are plain inputs, driven by the surrounding register logic.

Top module: `eth_da_filter`

## Requirements
- R1: Outside the decision cycle, `dec_vld_o` is 0, `accept_o` is 0 and `reason_o` is 0. In the decision cycle, `accept_o` is 1 exactly when `reason_o` is not 0. Reason codes are:
  - 0: reject
  - 1: exact station match
  - 2: individual hash hit
  - 3: group hash hit
  - 4: pause accept
- R2: `dec_vld_o` is high for exactly one cycle. It rises at the second rising clock edge counted from the edge that samples the sixth address byte, so it is registered one edge after that sampling edge.
- R3: The hash index is bits [31:26] of a CRC over the six bytes. The CRC uses polynomial 0x04C11DB7, starts at 0xFFFFFFFF, has no final inversion, and takes each byte least significant bit first. For each bit: the feedback is CRC[31] XOR the data bit, the CRC shifts left by one, and it is XORed with the polynomial when the feedback is 1.
- R4: Bit 0 of the first address byte is the group flag: 1 means a group address, 0 means an individual address. Byte k of an address is bits [8k+7:8k] of any 48-bit address port.
- R5: An individual address equal to `station_addr_i` gives reason 1, whatever the individual table holds.
- R6: For any other individual address, the individual table decides. Index bit 5 (CRC bit 31) selects the table half: 1 selects `ind_tbl_hi_i` and 0 selects `ind_tbl_lo_i`. Index bits 4:0 give the bit position within that half. A set bit gives reason 2, and a clear bit gives reason 0.
- R7: A group address equal to 01-80-C2-00-00-01 (first byte first) gives reason 4 when `flow_ctl_en_i` is 1, whatever the group table holds.
- R8: Any other group address, including the pause address when `flow_ctl_en_i` is 0, is looked up in the group table in the same way as R6. A hit gives reason 3 and a miss gives reason 0. The individual table and the station address have no effect on group addresses.
- R9: `start_i` sets the byte count to zero and the CRC to all ones, even in the middle of an address. A partly received address then produces no decision. A byte presented in the same cycle as `start_i` is the first byte of the new address.
- R10: Bytes presented after the sixth byte, and before the next `start_i`, are ignored. They produce no further decision.
- R11: Cycles with `byte_vld_i` low do not advance the address. Gaps between bytes do not change the outcome.
- R12: After reset no decision is issued until a complete address has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new destination address |
| byte_vld_i | input | 1 | `byte_i` carries an address byte this cycle |
| byte_i | input | 8 | Address byte, in arrival order |
| station_addr_i | input | 48 | Station address, byte 0 in bits [7:0] |
| flow_ctl_en_i | input | 1 | Enables acceptance of the pause address |
| grp_tbl_hi_i | input | 32 | Group hash bins 32 to 63 |
| grp_tbl_lo_i | input | 32 | Group hash bins 0 to 31 |
| ind_tbl_hi_i | input | 32 | Individual hash bins 32 to 63 |
| ind_tbl_lo_i | input | 32 | Individual hash bins 0 to 31 |
| dec_vld_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted (valid with `dec_vld_o`) |
| reason_o | output | 3 | Reason code, see R1 |

## Verification
The hardest case to reach from the ports is a specific hash bin: an address cannot be chosen to land in a given bin without inverting the CRC. The bench therefore works the other way round. It generates many arithmetic addresses and computes the CRC of each in its own model. For each address it programs the table with only the predicted bin set, and then with every bin set except that one. This checks the half-select bit and the bit position across a wide spread of bins, for both tables. Aborted addresses, bytes offered together with the start strobe, and surplus bytes after the sixth are driven in separate directed sequences.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

  typedef enum logic [2:0] {
    RSN_REJECT   = 3'd0,
    RSN_EXACT    = 3'd1,
    RSN_IND_HASH = 3'd2,
    RSN_GRP_HASH = 3'd3,
    RSN_PAUSE    = 3'd4
  } reason_e;

  localparam logic [31:0] ETH_CRC_POLY = 32'h04C11DB7;

  // Pause address 01-80-C2-00-00-01, first byte in the low bits.
  localparam logic [47:0] ETH_PAUSE_DA = 48'h0100_00C2_8001;

  // Index into the per-class table arrays.
  localparam int TBL_GRP = 0;
  localparam int TBL_IND = 1;

endpackage

// File: rtl/eaf_crc_byte.sv
// One byte of a CRC update, least significant data bit first.
module eaf_crc_byte #(
  parameter int          CRC_W = 32,
  parameter logic [31:0] POLY  = 32'h04C11DB7
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_o
);

  localparam logic [CRC_W-1:0] POLY_W = CRC_W'(POLY);

  always_comb begin
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = crc_i;
    for (int b = 0; b < 8; b++) begin
      fb  = acc[CRC_W-1] ^ byte_i[b];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY_W;
    end
    crc_o = acc;
  end

endmodule

// File: rtl/eaf_collect.sv
// Gathers the address bytes, keeps the running CRC and flags completion.
module eaf_collect #(
  parameter int          ADDR_BYTES = 6,
  parameter int          CRC_W      = 32,
  parameter int          HASH_W     = 6,
  parameter logic [31:0] POLY       = 32'h04C11DB7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    byte_vld_i,
  input  logic [7:0]              byte_i,
  output logic [8*ADDR_BYTES-1:0] addr_o,
  output logic [HASH_W-1:0]       hash_idx_o,
  output logic                    done_o
);

  localparam int                ADDR_W = 8 * ADDR_BYTES;
  localparam int                CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_base;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_base, crc_upd;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              take, ctl_en;

  eaf_crc_byte #(
    .CRC_W (CRC_W),
    .POLY  (POLY)
  ) u_crc_byte (
    .crc_i  (crc_base),
    .byte_i (byte_i),
    .crc_o  (crc_upd)
  );

  // Next-state logic.
  always_comb begin
    cnt_base = start_i ? '0 : cnt_q;
    crc_base = start_i ? '1 : crc_q;
    take     = byte_vld_i && (cnt_base < CNT_FULL);
    ctl_en   = start_i || take;
    cnt_d    = cnt_base;
    crc_d    = crc_base;
    addr_d   = addr_q;
    done_d   = 1'b0;
    if (take) begin
      cnt_d                     = cnt_base + 1'b1;
      crc_d                     = crc_upd;
      addr_d[{cnt_base, 3'b000} +: 8] = byte_i;
      done_d                    = (cnt_base == CNT_LAST);
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= '1;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctl_en) begin
        cnt_q <= cnt_d;
        crc_q <= crc_d;
      end
      if (take) addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o     = addr_q;
  assign hash_idx_o = crc_q[CRC_W-1 -: HASH_W];
  assign done_o     = done_q;

  // R9: a start without a byte leaves an empty address and a fresh CRC.
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !byte_vld_i |=> (cnt_q == '0) && (crc_q == '1));

  // R10: the byte count never passes the address length.
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R2: completion is flagged only once the address is full.
  a_r2_done_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cnt_q == CNT_FULL);

  // R11: idle cycles leave the collection state untouched.
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !byte_vld_i |=> $stable(cnt_q) && $stable(crc_q) && $stable(addr_q));

endmodule

// File: rtl/eaf_hash_lookup.sv
// Picks one bit of a 64-bin table split into two halves.
module eaf_hash_lookup #(
  parameter int HASH_W = 6,
  parameter int TBL_W  = 32
) (
  input  logic [HASH_W-1:0] hash_idx_i,
  input  logic [TBL_W-1:0]  tbl_hi_i,
  input  logic [TBL_W-1:0]  tbl_lo_i,
  output logic              hit_o
);

  localparam int POS_W = HASH_W - 1;

  logic [POS_W-1:0] pos;
  logic             half_sel;

  always_comb begin
    half_sel = hash_idx_i[HASH_W-1];
    pos      = hash_idx_i[POS_W-1:0];
    hit_o    = half_sel ? tbl_hi_i[pos] : tbl_lo_i[pos];
  end

endmodule

// File: rtl/eaf_decide.sv
// Ordered acceptance flow and registered decision outputs.
module eaf_decide
  import eaf_pkg::*;
#(
  parameter int          ADDR_W     = 48,
  parameter int          HASH_W     = 6,
  parameter int          TBL_W      = 32,
  parameter logic [47:0] PAUSE_ADDR = 48'h0100_00C2_8001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HASH_W-1:0] hash_idx_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic              fce_i,
  input  logic [TBL_W-1:0]  grp_hi_i,
  input  logic [TBL_W-1:0]  grp_lo_i,
  input  logic [TBL_W-1:0]  ind_hi_i,
  input  logic [TBL_W-1:0]  ind_lo_i,
  output logic              dec_vld_o,
  output logic              accept_o,
  output reason_e           reason_o
);

  localparam int                N_TBL   = 2;
  localparam logic [ADDR_W-1:0] PAUSE_W = ADDR_W'(PAUSE_ADDR);

  logic [N_TBL-1:0][TBL_W-1:0] tbl_hi, tbl_lo;
  logic [N_TBL-1:0]            tbl_hit;
  logic                        is_grp, exact, pause;
  reason_e                     rsn_d, rsn_q;
  logic                        vld_d, vld_q, acc_d, acc_q;

  assign tbl_hi[TBL_GRP] = grp_hi_i;
  assign tbl_lo[TBL_GRP] = grp_lo_i;
  assign tbl_hi[TBL_IND] = ind_hi_i;
  assign tbl_lo[TBL_IND] = ind_lo_i;

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    eaf_hash_lookup #(
      .HASH_W (HASH_W),
      .TBL_W  (TBL_W)
    ) u_lookup (
      .hash_idx_i (hash_idx_i),
      .tbl_hi_i   (tbl_hi[t]),
      .tbl_lo_i   (tbl_lo[t]),
      .hit_o      (tbl_hit[t])
    );
  end

  // Next-state logic: group flag, exact match, pause, then hash.
  always_comb begin
    is_grp = addr_i[0];
    exact  = (addr_i == station_i);
    pause  = (addr_i == PAUSE_W);
    rsn_d  = RSN_REJECT;
    if (done_i) begin
      if (!is_grp) begin
        if (exact)                 rsn_d = RSN_EXACT;
        else if (tbl_hit[TBL_IND]) rsn_d = RSN_IND_HASH;
      end else begin
        if (pause && fce_i)        rsn_d = RSN_PAUSE;
        else if (tbl_hit[TBL_GRP]) rsn_d = RSN_GRP_HASH;
      end
    end
    vld_d = done_i;
    acc_d = done_i && (rsn_d != RSN_REJECT);
  end

  // Output registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      rsn_q <= RSN_REJECT;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
      rsn_q <= rsn_d;
    end
  end

  assign dec_vld_o = vld_q;
  assign accept_o  = acc_q;
  assign reason_o  = rsn_q;

  // R2: a completed address is answered at the next edge.
  a_r2_dec_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> dec_vld_o);

  // R2: the decision strobe lasts one cycle.
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |=> !dec_vld_o);

  // R1: outputs are quiet outside the decision cycle.
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld_o |-> !accept_o && (reason_o == RSN_REJECT));

  // R4: group reasons only for addresses with the group flag set.
  a_r4_group_path: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && (reason_o == RSN_GRP_HASH || reason_o == RSN_PAUSE) |-> $past(addr_i[0]));

  // R5: an exact match is only reported for individual addresses.
  a_r5_exact_indiv: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && reason_o == RSN_EXACT |-> !$past(addr_i[0]));

  // R7: pause acceptance requires flow control to be enabled.
  a_r7_pause_fce: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && reason_o == RSN_PAUSE |-> $past(fce_i));

endmodule

// File: rtl/eth_da_filter.sv
// Destination address filter: byte collection, CRC hash and decision.
module eth_da_filter
  import eaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int CRC_W      = 32,
  parameter int HASH_W     = 6,
  parameter int TBL_W      = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic [47:0] station_addr_i,
  input  logic        flow_ctl_en_i,
  input  logic [31:0] grp_tbl_hi_i,
  input  logic [31:0] grp_tbl_lo_i,
  input  logic [31:0] ind_tbl_hi_i,
  input  logic [31:0] ind_tbl_lo_i,
  output logic        dec_vld_o,
  output logic        accept_o,
  output logic [2:0]  reason_o
);

  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic [ADDR_W-1:0] addr;
  logic [HASH_W-1:0] hash_idx;
  logic              done;
  reason_e           reason;

  eaf_collect #(
    .ADDR_BYTES (ADDR_BYTES),
    .CRC_W      (CRC_W),
    .HASH_W     (HASH_W),
    .POLY       (ETH_CRC_POLY)
  ) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .addr_o     (addr),
    .hash_idx_o (hash_idx),
    .done_o     (done)
  );

  eaf_decide #(
    .ADDR_W     (ADDR_W),
    .HASH_W     (HASH_W),
    .TBL_W      (TBL_W),
    .PAUSE_ADDR (ETH_PAUSE_DA)
  ) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .addr_i     (addr),
    .hash_idx_i (hash_idx),
    .station_i  (station_addr_i),
    .fce_i      (flow_ctl_en_i),
    .grp_hi_i   (grp_tbl_hi_i),
    .grp_lo_i   (grp_tbl_lo_i),
    .ind_hi_i   (ind_tbl_hi_i),
    .ind_lo_i   (ind_tbl_lo_i),
    .dec_vld_o  (dec_vld_o),
    .accept_o   (accept_o),
    .reason_o   (reason)
  );

  assign reason_o = reason;

endmodule

// File: tb/test_eth_da_filter.sv
module test_eth_da_filter;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        byte_vld_i;
  logic [7:0]  byte_i;
  logic [47:0] station_addr_i;
  logic        flow_ctl_en_i;
  logic [31:0] grp_tbl_hi_i, grp_tbl_lo_i, ind_tbl_hi_i, ind_tbl_lo_i;
  logic        dec_vld_o;
  logic        accept_o;
  logic [2:0]  reason_o;

  int n_chk;
  int n_bad;

  localparam logic [47:0] PAUSE = 48'h0100_00C2_8001;

  eth_da_filter i_eth_da_filter (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .byte_vld_i     (byte_vld_i),
    .byte_i         (byte_i),
    .station_addr_i (station_addr_i),
    .flow_ctl_en_i  (flow_ctl_en_i),
    .grp_tbl_hi_i   (grp_tbl_hi_i),
    .grp_tbl_lo_i   (grp_tbl_lo_i),
    .ind_tbl_hi_i   (ind_tbl_hi_i),
    .ind_tbl_lo_i   (ind_tbl_lo_i),
    .dec_vld_o      (dec_vld_o),
    .accept_o       (accept_o),
    .reason_o       (reason_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R3: software model of the hash index.
  function automatic logic [5:0] sw_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[31] ^ a[k];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [47:0] gen_addr(input int i);
    logic [31:0] hi;
    logic [15:0] lo;
    hi = 32'(i) * 32'h9E37_79B1 + 32'h0123_4567;
    lo = 16'(i) * 16'h3C6B + 16'h00A5;
    return {lo, hi};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_bin(input int grp, input logic [5:0] idx, input logic invert);
    logic [31:0] hi, lo;
    hi = '0;
    lo = '0;
    if (idx[5]) hi[idx[4:0]] = 1'b1;
    else        lo[idx[4:0]] = 1'b1;
    if (invert) begin
      hi = ~hi;
      lo = ~lo;
    end
    if (grp != 0) begin
      grp_tbl_hi_i = hi;
      grp_tbl_lo_i = lo;
    end else begin
      ind_tbl_hi_i = hi;
      ind_tbl_lo_i = lo;
    end
  endtask

  // Six bytes with optional idle gaps; ends at the negedge after the sixth byte is sampled.
  task automatic send_bytes(input logic [47:0] a, input int gap);
    for (int k = 0; k < 6; k++) begin
      byte_vld_i = 1'b1;
      byte_i     = a[8*k +: 8];
      @(negedge clk);
      byte_vld_i = 1'b0;
      if (k < 5) begin
        for (int g = 0; g < gap; g++) @(negedge clk);
      end
    end
  endtask

  task automatic expect_dec(input string tag, input logic [2:0] rsn);
    chk({tag, " no early strobe"}, 32'(dec_vld_o), 32'd0);
    @(negedge clk);
    chk({tag, " strobe"}, 32'(dec_vld_o), 32'd1);
    chk({tag, " reason"}, 32'(reason_o), 32'(rsn));
    chk({tag, " R1 accept"}, 32'(accept_o), 32'(rsn != 3'd0));
    @(negedge clk);
    chk({tag, " R2 single"}, 32'(dec_vld_o), 32'd0);
  endtask

  task automatic frame(input string tag, input logic [47:0] a, input int gap, input logic [2:0] rsn);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    send_bytes(a, gap);
    expect_dec(tag, rsn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    bit          seen;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    byte_vld_i = 1'b0;
    byte_i = '0;
    station_addr_i = 48'h5544_3322_1100;
    flow_ctl_en_i = 1'b0;
    grp_tbl_hi_i = '0;
    grp_tbl_lo_i = '0;
    ind_tbl_hi_i = '0;
    ind_tbl_lo_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: quiet after reset.
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R12 reset strobe", 32'(dec_vld_o), 32'd0);
      chk("R12 reset accept", 32'(accept_o), 32'd0);
      chk("R12 reset reason", 32'(reason_o), 32'd0);
    end

    // R5: exact station match wins regardless of the individual table.
    frame("R5 exact, empty table", station_addr_i, 0, 3'd1);
    ind_tbl_hi_i = '1;
    ind_tbl_lo_i = '1;
    frame("R5 exact, full table", station_addr_i, 2, 3'd1);

    // R3 R6 R11: individual hash sweep over many bins.
    grp_tbl_hi_i = '1;
    grp_tbl_lo_i = '1;
    for (int i = 0; i < 96; i++) begin
      a = gen_addr(i);
      a[0] = 1'b0;
      ix = sw_idx(a);
      set_bin(0, ix, 1'b0);
      frame("R6 ind hit", a, i % 3, 3'd2);
      set_bin(0, ix, 1'b1);
      frame("R6 ind miss", a, (i + 1) % 3, 3'd0);
    end

    // R3 R8 R11: group hash sweep; individual table and station ignored.
    ind_tbl_hi_i = '1;
    ind_tbl_lo_i = '1;
    for (int i = 0; i < 96; i++) begin
      a = gen_addr(i + 500);
      a[0] = 1'b1;
      station_addr_i = a;
      ix = sw_idx(a);
      set_bin(1, ix, 1'b0);
      frame("R8 grp hit", a, i % 2, 3'd3);
      set_bin(1, ix, 1'b1);
      frame("R8 grp miss", a, i % 4, 3'd0);
    end
    station_addr_i = 48'h5544_3322_1100;

    // R7: pause address with and without flow control.
    grp_tbl_hi_i = '0;
    grp_tbl_lo_i = '0;
    flow_ctl_en_i = 1'b1;
    frame("R7 pause accept", PAUSE, 0, 3'd4);
    flow_ctl_en_i = 1'b0;
    frame("R8 pause no fce miss", PAUSE, 0, 3'd0);
    set_bin(1, sw_idx(PAUSE), 1'b0);
    frame("R8 pause no fce hit", PAUSE, 1, 3'd3);

    // R9: abort after three bytes, then a full individual address.
    ind_tbl_hi_i = '0;
    ind_tbl_lo_i = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      byte_vld_i = 1'b1;
      byte_i = 8'hE0 + 8'(k);
      @(negedge clk);
    end
    byte_vld_i = 1'b0;
    frame("R9 restart exact", station_addr_i, 0, 3'd1);

    // R9: a byte alongside the start strobe is the first byte.
    start_i = 1'b1;
    byte_vld_i = 1'b1;
    byte_i = station_addr_i[7:0];
    @(negedge clk);
    start_i = 1'b0;
    byte_vld_i = 1'b0;
    for (int k = 1; k < 6; k++) begin
      byte_vld_i = 1'b1;
      byte_i = station_addr_i[8*k +: 8];
      @(negedge clk);
    end
    byte_vld_i = 1'b0;
    expect_dec("R9 start with byte", 3'd1);

    // R10: surplus bytes produce no further decision.
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      byte_vld_i = 1'b1;
      byte_i = station_addr_i[8*k +: 8];
      @(negedge clk);
      if (dec_vld_o) seen = 1'b1;
    end
    byte_vld_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (dec_vld_o) seen = 1'b1;
    end
    chk("R10 surplus ignored", 32'(seen), 32'd0);
    frame("R10 next address", station_addr_i, 1, 3'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule